// File: doc/BRIEF.md
# Clock Glitch Margining Generator

This block drives a test clock for a device under test from a fast reference clock. Every output cycle normally lasts a fixed number of reference ticks. After a start request, one output cycle at a fixed cadence is made shorter than nominal. Only its low phase is cut, so the high phase is never a runt. The cut begins at one tenth of the nominal period. It grows by another tenth each time a level passes without trouble, up to half the nominal period.

An external monitor watches the device and raises an anomaly input when it sees a fault. An anomaly stops the sweep and holds the level at which it occurred. A sweep that clears the deepest level without an anomaly ends with a done flag. At any other time the output is a plain clock at the nominal period.

Top module: `glitch_sweep_gen`

## Requirements
- R1: After reset, and whenever no sweep is running, every output period equals NOM_TICKS reference ticks. The level reads 0 after reset, and the sweeping, done and fault flags read 0.
- R2: Every output cycle, nominal or shortened, starts with a high phase of exactly NOM_TICKS/2 - NOM_TICKS/20 reference ticks. A nominal cycle's low phase takes the rest of the period.
- R3: While a sweep runs, only one output cycle in every CADENCE is shortened. Between two consecutive shortened cycles there are exactly CADENCE-1 nominal cycles.
- R4: A shortened cycle at level L (1..MAX_LEVEL) lasts NOM_TICKS - L*NOM_TICKS/10 ticks. The cut is taken from the low phase only.
- R5: A start pulse from the idle, done or fault state begins a sweep at level 1, and each level inserts SHOTS_PER_LEVEL shortened cycles.
- R6: The level rises by exactly one at the next scheduled insertion slot. This happens only after SHOTS_PER_LEVEL insertions at the current level, with no anomaly seen up to that slot.
- R7: When the insertions at level MAX_LEVEL are all complete and no anomaly has been seen by the next slot, done is set, sweeping clears, no further shortened cycles appear, and the level stays at MAX_LEVEL.
- R8: An anomaly seen while sweeping sets fault, clears sweeping and freezes the level at its current value. No further shortened cycles follow, and done and fault are never both set.
- R9: A start pulse while a sweep is running has no effect on the level or on the sequence of shortened cycles. A start pulse after done or fault clears both flags.
- R10: An anomaly while no sweep is running has no effect on the fault and done flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock; all timing is counted in its ticks |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a sweep |
| anomaly_i | input | 1 | Fault observed on the device under test |
| clk_glitch_o | output | 1 | Test clock with periodic shortened cycles |
| level_o | output | $clog2(MAX_LEVEL+1) | Current shortening level, 0 before the first sweep |
| sweeping_o | output | 1 | A sweep is in progress |
| done_o | output | 1 | Sweep reached the deepest level with no anomaly |
| fault_o | output | 1 | Sweep stopped on an anomaly; level_o holds the level |

## Verification
Two situations are hard to reach from the ports. The first is an anomaly that arrives in the quiet window after the last insertion of a level but before the slot where the level would rise; in that case the stop must report the old level. The second is the deepest level, whose low phase shrinks to a single reference tick. The bench runs the block with a short cadence. It measures each output cycle directly from clk_glitch_o, counts the shortened cycles as they complete, and raises the anomaly right after a chosen count, such as the last shot of level 2. The sweep that runs to the deepest level also brings the one-tick low phase out at the pin.

// File: rtl/glsw_pkg.sv
// Package glsw_pkg
// Holds the types shared by the clock glitch margining generator.
// Assumes nothing beyond standard SystemVerilog.
package glsw_pkg;

    // Sweep controller states.
    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_RUN   = 2'd1,
        SW_DONE  = 2'd2,
        SW_FAULT = 2'd3
    } sweep_state_t;

endpackage

// File: rtl/glsw_period_gen.sv
// Module glsw_period_gen
// Counts reference ticks within one output cycle and drives the output clock.
// Each cycle has a fixed high phase followed by a low phase. The low phase
// is shortened by load_cut_i, which is sampled on the last tick of the
// previous cycle.
// Assumes load_cut_i < NOM_TICKS - HIGH_TICKS, so at least one low tick remains.
module glsw_period_gen #(
    parameter int NOM_TICKS  = 20,
    parameter int HIGH_TICKS = 9,
    parameter int CNT_W      = $clog2(NOM_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_cut_i,
    output logic             cyc_end_o,
    output logic             clk_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] len_q;
    logic             clk_q;

    // Flags the last tick of the current cycle.
    assign cyc_end_o = (cnt_q == len_q - CNT_W'(1));

    // Next tick position within the cycle.
    assign cnt_nxt = cyc_end_o ? '0 : cnt_q + CNT_W'(1);

    // Tick counter, cycle length latch and registered clock output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= CNT_W'(NOM_TICKS);
            clk_q <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            if (cyc_end_o) begin
                len_q <= CNT_W'(NOM_TICKS) - load_cut_i;
            end
            clk_q <= (cnt_nxt < CNT_W'(HIGH_TICKS));
        end
    end

    assign clk_o = clk_q;

    // R4: the tick position never runs past the length of the cycle.
    p_cnt_in_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len_q);

    // R2: every cycle keeps at least one low tick after its high phase.
    p_low_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        len_q > CNT_W'(HIGH_TICKS));

    // R2: a rising edge of the output only happens at the start of a cycle.
    p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> (cnt_q == '0));

endmodule

// File: rtl/glsw_cadence.sv
// Module glsw_cadence
// Numbers the output cycles modulo CADENCE and flags when the next cycle
// is the insertion slot, which is the last index of the cadence.
// A restart pulse renumbers the cycle in progress as index 0.
// Assumes CADENCE >= 2.
module glsw_cadence #(
    parameter int CADENCE = 1000,
    parameter int IDX_W   = $clog2(CADENCE)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic cyc_end_i,
    output logic next_is_slot_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CADENCE - 1);
    localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(CADENCE - 2);

    logic [IDX_W-1:0] idx_q;

    // The cycle after the one ending now is the slot.
    assign next_is_slot_o = (idx_q == PRE_IDX);

    // Cycle index counter with restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (restart_i) begin
            idx_q <= '0;
        end else if (cyc_end_i) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
        end
    end

    // R3: the cycle index stays inside the cadence.
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);

    // R3: the index only moves at a cycle end or on a restart.
    p_idx_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cyc_end_i) && !$past(restart_i)) |-> $stable(idx_q));

endmodule

// File: rtl/glsw_sweep_ctrl.sv
// Module glsw_sweep_ctrl
// Runs the level sweep. At each insertion slot it either schedules one
// shortened cycle, or it steps to the next level once the current level
// has had all its shots and a quiet observation window, or it ends the
// sweep after the deepest level. An anomaly during a sweep stops it.
// Assumes slot_i pulses for one reference tick, at the end of the cycle
// that precedes an insertion slot.
module glsw_sweep_ctrl
    import glsw_pkg::*;
#(
    parameter int MAX_LEVEL       = 5,
    parameter int SHOTS_PER_LEVEL = 4,
    parameter int LVL_W           = $clog2(MAX_LEVEL + 1),
    parameter int SHOT_W          = $clog2(SHOTS_PER_LEVEL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             anomaly_i,
    input  logic             slot_i,
    output logic             glitch_go_o,
    output logic [LVL_W-1:0] glitch_lvl_o,
    output logic [LVL_W-1:0] level_o,
    output logic             sweeping_o,
    output logic             done_o,
    output logic             fault_o
);

    sweep_state_t      state_q;
    logic [LVL_W-1:0]  level_q;
    logic [SHOT_W-1:0] shot_q;
    logic              running;
    logic              shots_spent;
    logic              at_top;
    logic              slot_clean;
    logic              step_up;
    logic              finish;

    // Decode of the current sweep position.
    always_comb begin
        running     = (state_q == SW_RUN);
        shots_spent = (shot_q == SHOT_W'(SHOTS_PER_LEVEL));
        at_top      = (level_q == LVL_W'(MAX_LEVEL));
        slot_clean  = running && slot_i && !anomaly_i;
        step_up     = slot_clean && shots_spent;
        finish      = step_up && at_top;
    end

    // Insertion request and the level it uses.
    always_comb begin
        glitch_go_o  = slot_clean && !finish;
        glitch_lvl_o = (step_up && !at_top) ? level_q + LVL_W'(1) : level_q;
    end

    // Sweep state, level and shot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            level_q <= '0;
            shot_q  <= '0;
        end else begin
            case (state_q)
                SW_RUN: begin
                    if (anomaly_i) begin
                        state_q <= SW_FAULT;
                    end else if (slot_i) begin
                        if (finish) begin
                            state_q <= SW_DONE;
                        end else if (step_up) begin
                            level_q <= level_q + LVL_W'(1);
                            shot_q  <= SHOT_W'(1);
                        end else begin
                            shot_q <= shot_q + SHOT_W'(1);
                        end
                    end
                end
                default: begin
                    if (start_i) begin
                        state_q <= SW_RUN;
                        level_q <= LVL_W'(1);
                        shot_q  <= '0;
                    end
                end
            endcase
        end
    end

    assign level_o    = level_q;
    assign sweeping_o = running;
    assign done_o     = (state_q == SW_DONE);
    assign fault_o    = (state_q == SW_FAULT);

    // R5: the shot counter never passes the shots allowed per level.
    p_shot_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shot_q <= SHOT_W'(SHOTS_PER_LEVEL));

    // R6: during a sweep the level only ever rises by one.
    p_level_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ($past(state_q) == SW_RUN) && (level_q != $past(level_q)))
            |-> (level_q == $past(level_q) + LVL_W'(1)));

    // R8: an anomaly during a sweep stops it on the next edge.
    p_stop_on_anomaly_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && anomaly_i) |=> fault_o);

    // R8: a stopped sweep keeps its level until restarted.
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && $past(fault_o)) |-> $stable(level_q));

    // R8: done and fault are exclusive.
    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));

    // R7: a finished sweep sits at the deepest level.
    p_done_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (level_q == LVL_W'(MAX_LEVEL)));

endmodule

// File: rtl/glitch_sweep_gen.sv
// Module glitch_sweep_gen
// Top of the clock glitch margining generator. It ties together the
// period generator, the cadence counter and the sweep controller. The
// cut applied to a scheduled cycle is its level times one tenth of the
// nominal period.
// Assumes NOM_TICKS is a multiple of 20, so that every step and the
// half-step offset of the high phase are whole ticks, and MAX_LEVEL <= 5.
module glitch_sweep_gen #(
    parameter int NOM_TICKS       = 20,
    parameter int CADENCE         = 1000,
    parameter int SHOTS_PER_LEVEL = 4,
    parameter int MAX_LEVEL       = 5,
    parameter int LVL_W           = $clog2(MAX_LEVEL + 1)
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             anomaly_i,
    output logic             clk_glitch_o,
    output logic [LVL_W-1:0] level_o,
    output logic             sweeping_o,
    output logic             done_o,
    output logic             fault_o
);

    localparam int STEP_TICKS = NOM_TICKS / 10;
    localparam int HIGH_TICKS = NOM_TICKS / 2 - STEP_TICKS / 2;
    localparam int CNT_W      = $clog2(NOM_TICKS + 1);

    logic             cyc_end;
    logic             next_is_slot;
    logic             slot;
    logic             glitch_go;
    logic [LVL_W-1:0] glitch_lvl;
    logic [CNT_W-1:0] cut;
    logic             restart;

    // A start is only honoured when no sweep is running.
    assign restart = start_i && !sweeping_o;

    // Insertion slot marker for the controller.
    assign slot = cyc_end && next_is_slot;

    // Cut length for the next cycle.
    assign cut = glitch_go ? CNT_W'(glitch_lvl) * CNT_W'(STEP_TICKS) : '0;

    glsw_period_gen #(
        .NOM_TICKS (NOM_TICKS),
        .HIGH_TICKS(HIGH_TICKS),
        .CNT_W     (CNT_W)
    ) u_period (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .load_cut_i(cut),
        .cyc_end_o (cyc_end),
        .clk_o     (clk_glitch_o)
    );

    glsw_cadence #(
        .CADENCE(CADENCE)
    ) u_cadence (
        .clk           (clk_ref),
        .rst_n         (rst_n),
        .restart_i     (restart),
        .cyc_end_i     (cyc_end),
        .next_is_slot_o(next_is_slot)
    );

    glsw_sweep_ctrl #(
        .MAX_LEVEL      (MAX_LEVEL),
        .SHOTS_PER_LEVEL(SHOTS_PER_LEVEL),
        .LVL_W          (LVL_W)
    ) u_sweep (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .anomaly_i   (anomaly_i),
        .slot_i      (slot),
        .glitch_go_o (glitch_go),
        .glitch_lvl_o(glitch_lvl),
        .level_o     (level_o),
        .sweeping_o  (sweeping_o),
        .done_o      (done_o),
        .fault_o     (fault_o)
    );

    // R1, R7: no cut reaches the period generator once a sweep has ended.
    p_quiet_after_stop_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (done_o || fault_o) |-> (cut == '0));

    // R4: a requested insertion always carries a level inside the sweep range.
    p_level_in_range_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        glitch_go |-> ((glitch_lvl != '0) && (glitch_lvl <= LVL_W'(MAX_LEVEL))));

endmodule

// File: tb/test_glitch_sweep_gen.sv
// Scoreboard bench: driver tasks queue the expected shortened periods and
// a monitor measures every output cycle at the pin and compares.
module test_glitch_sweep_gen;

    localparam int NOM     = 20;
    localparam int CAD     = 6;
    localparam int SHOTS   = 2;
    localparam int MAXL    = 5;
    localparam int STEP    = NOM / 10;
    localparam int HIGH    = NOM / 2 - STEP / 2;
    localparam int LVL_W   = $clog2(MAXL + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             anomaly = 1'b0;
    logic             clk_g;
    logic [LVL_W-1:0] level;
    logic             sweeping;
    logic             done;
    logic             fault;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int glitch_seen = 0;
    int nominal_since = 0;
    bit first_after_start = 1'b1;
    bit mon_en = 1'b0;

    always #4 clk = ~clk;

    glitch_sweep_gen #(
        .NOM_TICKS      (NOM),
        .CADENCE        (CAD),
        .SHOTS_PER_LEVEL(SHOTS),
        .MAX_LEVEL      (MAXL)
    ) i_glitch_sweep_gen (
        .clk_ref     (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .anomaly_i   (anomaly),
        .clk_glitch_o(clk_g),
        .level_o     (level),
        .sweeping_o  (sweeping),
        .done_o      (done),
        .fault_o     (fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measures each output cycle and scores it.
    bit prev_g = 1'b1;
    bit synced = 1'b0;
    int hi_cnt = 0;
    int lo_cnt = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (clk_g && !prev_g) begin
                if (synced) begin
                    chk(hi_cnt == HIGH, "R2 high phase", hi_cnt, HIGH);
                    if (hi_cnt + lo_cnt == NOM) begin
                        nominal_since++;
                    end else if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected short cycle", hi_cnt + lo_cnt, NOM);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(hi_cnt + lo_cnt == e, "R4 short cycle length", hi_cnt + lo_cnt, e);
                        if (!first_after_start)
                            chk(nominal_since == CAD - 1, "R3 spacing", nominal_since, CAD - 1);
                        first_after_start = 1'b0;
                        nominal_since = 0;
                        glitch_seen++;
                    end
                end
                synced = 1'b1;
                hi_cnt = 1;
                lo_cnt = 0;
            end else if (clk_g) begin
                hi_cnt++;
            end else begin
                lo_cnt++;
            end
            prev_g = clk_g;
        end
    end

    task automatic push_levels(input int upto_shot);
        for (int k = 0; k < upto_shot; k++) begin
            exp_q.push_back(NOM - (k / SHOTS + 1) * STEP);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        first_after_start = 1'b1;
        nominal_since = 0;
    endtask

    task automatic pulse_anomaly();
        @(negedge clk) anomaly = 1'b1;
        @(negedge clk) anomaly = 1'b0;
    endtask

    task automatic wait_periods(input int n);
        repeat (n * NOM) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(level == 0, "R1 reset level", int'(level), 0);
        chk(!sweeping && !done && !fault, "R1 reset flags",
            int'({sweeping, done, fault}), 0);
        mon_en = 1'b1;
        wait_periods(2 * CAD + 2);

        // R10: anomaly while idle is ignored.
        pulse_anomaly();
        @(negedge clk);
        chk(!fault && !done, "R10 idle anomaly", int'({done, fault}), 0);

        // R5, R7: full sweep without an anomaly.
        push_levels(SHOTS * MAXL);
        pulse_start();
        chk(level == 1 && sweeping, "R5 start level", int'(level), 1);
        wait (glitch_seen == 1);
        pulse_start();
        chk(level == 1 && sweeping, "R9 start while running", int'(level), 1);
        for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
        chk(done == 1'b1, "R7 done set", int'(done), 1);
        chk(level == MAXL, "R7 level at top", int'(level), MAXL);
        chk(!fault && !sweeping, "R7 flags", int'({sweeping, fault}), 0);
        chk(glitch_seen == SHOTS * MAXL, "R6 shots seen", glitch_seen, SHOTS * MAXL);
        wait_periods(3 * CAD);
        chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
        chk(glitch_seen == SHOTS * MAXL, "R7 no glitch after done", glitch_seen, SHOTS * MAXL);

        // R10: anomaly after done is ignored.
        pulse_anomaly();
        @(negedge clk);
        chk(done && !fault, "R10 anomaly after done", int'({done, fault}), 2);

        // R6, R8: anomaly in the window after the last shot of level 2.
        base = glitch_seen;
        push_levels(2 * SHOTS);
        pulse_start();
        chk(!done && !fault && level == 1, "R9 restart clears", int'({done, fault}), 0);
        wait (glitch_seen == base + 2 * SHOTS);
        pulse_anomaly();
        chk(fault == 1'b1, "R8 fault set", int'(fault), 1);
        chk(level == 2, "R6 level held at boundary", int'(level), 2);
        wait_periods(3 * CAD);
        chk(level == 2 && !sweeping, "R8 level frozen", int'(level), 2);
        chk(glitch_seen == base + 2 * SHOTS, "R8 no glitch after fault",
            glitch_seen, base + 2 * SHOTS);
        chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);

        // R8, R9: restart from fault and stop after the first shot.
        base = glitch_seen;
        push_levels(1);
        pulse_start();
        chk(!fault && level == 1, "R9 restart from fault", int'(fault), 0);
        wait (glitch_seen == base + 1);
        pulse_anomaly();
        chk(fault && level == 1, "R8 stop at level 1", int'(level), 1);
        wait_periods(2 * CAD);
        chk(glitch_seen == base + 1, "R8 quiet after stop", glitch_seen, base + 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule